// File: doc/BRIEF.md
# Shared-Pool Multi-Queue Chunk Buffer

This block keeps several independent first-in first-out queues in one shared storage pool. Each entry is a 128-bit chunk, typically one pending register-write record. Storage is handed to a queue one block at a time, and a block is a fixed group of consecutive chunks. A queue is a singly linked chain of blocks. The links live in a separate next-block table indexed by block number, so the data array holds only payload.

Blocks that no queue owns wait on a free list. A push that fills the last chunk of its block moves the queue's write position to a new block taken from the head of the free list, and writes that block's number into the link entry of the block just filled. A pop that consumes the last chunk of a block follows that block's link and returns the block to the tail of the free list. Each queue position is a single word: the block number in the upper bits and the chunk offset in the low log2(chunks per block) bits. The position multiplied by 16 is therefore the byte address of the chunk in the data array. A build parameter selects one of three pool geometries.

The surrounding logic presents one push and one pop per cycle. Each carries a queue index. It reads the per-queue status and the global out-of-blocks flag to decide what it may push.

Top module: `sqp_pool_top`

## Requirements
- R1: After reset every queue is empty with a chunk count of 0. Queue i owns exactly one block, block i, with its read and write positions at chunk 0 of that block. The free list holds the remaining blocks in ascending order, and out_of_blocks is 0.
- R2: Each queue returns chunks in the order they were accepted. An accepted pop raises pop_valid for exactly one cycle, on the clock edge that samples the pop, with the chunk on pop_data.
- R3: q_chunks for a queue equals its accepted pushes minus its accepted pops. q_empty is 1 exactly when that count is 0.
- R4: pop_addr carries the byte address of the popped chunk: (block × chunks-per-block + chunk offset) × 16.
- R5: A push that writes the last chunk offset of its block takes the block at the head of the free list as the queue's next block. A freed block is appended at the tail, so freed blocks are reused in the order they were freed.
- R6: A pop of the last chunk offset of a block returns that block to the free list. q_blocks reports the number of blocks each queue owns. out_of_blocks is 1 exactly when the free list is empty.
- R7: A push that needs a new block while the free list is empty is refused. No queue state changes, and push_drop pulses for one cycle. q_full of a queue is 1 exactly when its write offset is the last of its block and the free list is empty. Pushes to queues with room are still accepted.
- R8: A pop to an empty queue is ignored and pulses pop_err, and pop_valid stays 0.
- R9: A queue index of NUM_Q or more is ignored. On push it pulses push_drop, and on pop it pulses pop_err.
- R10: A push and a pop in the same cycle are both serviced. Refusal and emptiness are judged on the state before that cycle. A block freed by the pop cannot serve the push of the same cycle, and a push to an empty queue cannot feed that queue's same-cycle pop.
- R11: GEOM selects 128 blocks of 8 chunks, 48 blocks of 8 chunks, or 64 blocks of 4 chunks. With 64×4 and six queues, one queue can hold 235 chunks while the other five each hold their single block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Push request |
| push_q | input | QW = clog2(NUM_Q) (3) | Queue index for the push |
| push_data | input | DATA_W (128) | Chunk to append |
| pop_en | input | 1 | Pop request |
| pop_q | input | QW (3) | Queue index for the pop |
| pop_valid | output | 1 | Pulse: pop_data/pop_addr hold a popped chunk |
| pop_data | output | DATA_W (128) | Popped chunk |
| pop_addr | output | POS_W+4 (14) | Byte address of the popped chunk in the pool |
| push_drop | output | 1 | Pulse: previous push refused |
| pop_err | output | 1 | Pulse: previous pop ignored |
| q_empty | output | NUM_Q (6) | Per-queue empty |
| q_full | output | NUM_Q (6) | Per-queue: next push would be refused |
| q_chunks | output | NUM_Q×CNT_W (66) | Per-queue chunk counts, queue i at bits i×CNT_W |
| q_blocks | output | NUM_Q×BCNT_W (48) | Per-queue owned-block counts, queue i at bits i×BCNT_W |
| out_of_blocks | output | 1 | Free list empty |

## Verification
The hardest state to reach is a drained free list where the pop leaving a block lands in the same cycle as a push that needs one. Only then is the rule tested that the freed block serves nothing until the next cycle. The stimulus fills one queue in the 64×4 geometry until it is refused. It then pops to the last chunk of the oldest block and issues that pop together with another push to the same queue. It then drains the queue through the recycled block, so the link table and the reuse order show in the popped byte addresses.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

    typedef enum logic [1:0] {
        GEOM_FULL    = 2'd0,
        GEOM_HALF    = 2'd1,
        GEOM_QUARTER = 2'd2
    } sqp_geom_e;

    // 16 bytes per 128-bit chunk
    localparam int BYTE_LOG2 = 4;

    function automatic int geom_blocks(input sqp_geom_e g);
        case (g)
            GEOM_HALF:    return 48;
            GEOM_QUARTER: return 64;
            default:      return 128;
        endcase
    endfunction

    function automatic int geom_chunk_log2(input sqp_geom_e g);
        return (g == GEOM_QUARTER) ? 2 : 3;
    endfunction

endpackage

// File: rtl/sqp_free_list.sv
module sqp_free_list #(
    parameter  int NUM_BLK = 128,
    parameter  int NUM_RES = 6,
    localparam int BLK_W   = $clog2(NUM_BLK),
    localparam int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    input  logic [BLK_W-1:0] give_blk,
    output logic [BLK_W-1:0] head_blk,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [BLK_W-1:0] head;
        logic [BLK_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } fl_state_t;

    fl_state_t st_d, st_q;
    logic [BLK_W-1:0] ent_q [NUM_BLK];

    function automatic logic [BLK_W-1:0] ring_inc(input logic [BLK_W-1:0] p);
        return (p == BLK_W'(NUM_BLK - 1)) ? '0 : p + BLK_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (take) st_d.head = ring_inc(st_q.head);
        if (give) st_d.tail = ring_inc(st_q.tail);
        st_d.cnt = st_q.cnt + CNT_W'(give) - CNT_W'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.head <= '0;
            st_q.tail <= BLK_W'((NUM_BLK - NUM_RES) % NUM_BLK);
            st_q.cnt  <= CNT_W'(NUM_BLK - NUM_RES);
        end else begin
            st_q <= st_d;
        end
    end

    // free list ring: blocks NUM_RES.. start out unowned, in ascending order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLK; i++)
                ent_q[i] <= (i < NUM_BLK - NUM_RES) ? BLK_W'(i + NUM_RES) : '0;
        end else if (give) begin
            ent_q[st_q.tail] <= give_blk;
        end
    end

    assign head_blk = ent_q[st_q.head];
    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;

    // R7: a block is never taken from an empty free list
    a_r7_take_needs_block: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.cnt != '0);

    // R6: returning a block never overfills the ring
    a_r6_give_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take) |-> st_q.cnt < CNT_W'(NUM_BLK));

endmodule

// File: rtl/sqp_link_table.sv
module sqp_link_table #(
    parameter  int NUM_BLK = 128,
    localparam int BLK_W   = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [BLK_W-1:0] wr_next,
    input  logic [BLK_W-1:0] rd_blk,
    output logic [BLK_W-1:0] rd_next
);

    logic [BLK_W-1:0] link_mem [NUM_BLK];

    always_ff @(posedge clk) begin
        if (we) link_mem[wr_blk] <= wr_next;
    end

    assign rd_next = link_mem[rd_blk];

endmodule

// File: rtl/sqp_chunk_store.sv
module sqp_chunk_store #(
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] chunk_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) chunk_mem[wr_idx] <= wr_data;
    end

    assign rd_data = chunk_mem[rd_idx];

endmodule

// File: rtl/sqp_pool_top.sv
module sqp_pool_top
    import sqp_pkg::*;
#(
    parameter  sqp_geom_e GEOM    = GEOM_FULL,
    parameter  int        NUM_Q   = 6,
    parameter  int        DATA_W  = 128,
    localparam int        NUM_BLK = geom_blocks(GEOM),
    localparam int        CH_LOG2 = geom_chunk_log2(GEOM),
    localparam int        BLK_W   = $clog2(NUM_BLK),
    localparam int        POS_W   = BLK_W + CH_LOG2,
    localparam int        DEPTH   = NUM_BLK << CH_LOG2,
    localparam int        ADDR_W  = POS_W + BYTE_LOG2,
    localparam int        QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int        CNT_W   = $clog2(DEPTH + 1),
    localparam int        BCNT_W  = $clog2(NUM_BLK + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_en,
    input  logic [QW-1:0]           push_q,
    input  logic [DATA_W-1:0]       push_data,
    input  logic                    pop_en,
    input  logic [QW-1:0]           pop_q,
    output logic                    pop_valid,
    output logic [DATA_W-1:0]       pop_data,
    output logic [ADDR_W-1:0]       pop_addr,
    output logic                    push_drop,
    output logic                    pop_err,
    output logic [NUM_Q-1:0]        q_empty,
    output logic [NUM_Q-1:0]        q_full,
    output logic [NUM_Q*CNT_W-1:0]  q_chunks,
    output logic [NUM_Q*BCNT_W-1:0] q_blocks,
    output logic                    out_of_blocks
);

    localparam int QW1 = QW + 1;

    typedef struct packed {
        logic [NUM_Q-1:0][POS_W-1:0]  wr_pos;
        logic [NUM_Q-1:0][POS_W-1:0]  rd_pos;
        logic [NUM_Q-1:0][CNT_W-1:0]  chunks;
        logic [NUM_Q-1:0][BCNT_W-1:0] blocks;
        logic                         pop_valid;
        logic [DATA_W-1:0]            pop_data;
        logic [ADDR_W-1:0]            pop_addr;
        logic                         push_drop;
        logic                         pop_err;
    } pool_state_t;

    pool_state_t st_d, st_q;

    // free list and tables
    logic              fl_take, fl_give, fl_empty;
    logic [BLK_W-1:0]  fl_head, fl_give_blk;
    logic [CNT_W-1:0]  fl_count_raw;
    logic              link_we;
    logic [BLK_W-1:0]  link_wr_blk, link_rd_blk, link_rd_next;
    logic [DATA_W-1:0] store_rdata;

    // request decode
    logic             push_in_rng, pop_in_rng;
    logic [QW-1:0]    push_idx, pop_idx;
    logic [POS_W-1:0] push_pos, pop_pos;
    logic             push_new_blk, push_acc, pop_acc, pop_last;

    sqp_free_list #(.NUM_BLK(NUM_BLK), .NUM_RES(NUM_Q)) free_list_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (fl_take),
        .give     (fl_give),
        .give_blk (fl_give_blk),
        .head_blk (fl_head),
        .empty    (fl_empty),
        .count    (fl_count_raw[$clog2(NUM_BLK+1)-1:0])
    );

    sqp_link_table #(.NUM_BLK(NUM_BLK)) link_table_i (
        .clk     (clk),
        .we      (link_we),
        .wr_blk  (link_wr_blk),
        .wr_next (fl_head),
        .rd_blk  (link_rd_blk),
        .rd_next (link_rd_next)
    );

    sqp_chunk_store #(.DEPTH(DEPTH), .IDX_W(POS_W), .DATA_W(DATA_W)) chunk_store_i (
        .clk     (clk),
        .we      (push_acc),
        .wr_idx  (push_pos),
        .wr_data (push_data),
        .rd_idx  (pop_pos),
        .rd_data (store_rdata)
    );

    always_comb begin
        st_d = st_q;

        push_in_rng  = ({1'b0, push_q} < QW1'(NUM_Q));
        pop_in_rng   = ({1'b0, pop_q} < QW1'(NUM_Q));
        push_idx     = push_in_rng ? push_q : '0;
        pop_idx      = pop_in_rng ? pop_q : '0;

        push_pos     = st_q.wr_pos[push_idx];
        push_new_blk = &push_pos[CH_LOG2-1:0];
        push_acc     = push_en && push_in_rng && !(push_new_blk && fl_empty);

        pop_pos      = st_q.rd_pos[pop_idx];
        pop_last     = &pop_pos[CH_LOG2-1:0];
        pop_acc      = pop_en && pop_in_rng && (pop_pos != st_q.wr_pos[pop_idx]);

        fl_take      = push_acc && push_new_blk;
        link_we      = fl_take;
        link_wr_blk  = push_pos[POS_W-1:CH_LOG2];
        fl_give      = pop_acc && pop_last;
        fl_give_blk  = pop_pos[POS_W-1:CH_LOG2];
        link_rd_blk  = pop_pos[POS_W-1:CH_LOG2];

        st_d.push_drop = push_en && !push_acc;
        st_d.pop_err   = pop_en && !pop_acc;
        st_d.pop_valid = pop_acc;

        if (push_acc) begin
            st_d.wr_pos[push_idx] = push_new_blk ? {fl_head, {CH_LOG2{1'b0}}}
                                                 : push_pos + POS_W'(1);
        end

        if (pop_acc) begin
            st_d.rd_pos[pop_idx] = pop_last ? {link_rd_next, {CH_LOG2{1'b0}}}
                                            : pop_pos + POS_W'(1);
            st_d.pop_data = store_rdata;
            st_d.pop_addr = {pop_pos, {BYTE_LOG2{1'b0}}};
        end

        for (int q = 0; q < NUM_Q; q++) begin
            st_d.chunks[q] = st_q.chunks[q]
                           + CNT_W'(push_acc && (push_idx == QW'(q)))
                           - CNT_W'(pop_acc && (pop_idx == QW'(q)));
            st_d.blocks[q] = st_q.blocks[q]
                           + BCNT_W'(fl_take && (push_idx == QW'(q)))
                           - BCNT_W'(fl_give && (pop_idx == QW'(q)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_Q; q++) begin
                st_q.wr_pos[q] <= POS_W'(q << CH_LOG2);
                st_q.rd_pos[q] <= POS_W'(q << CH_LOG2);
                st_q.chunks[q] <= '0;
                st_q.blocks[q] <= BCNT_W'(1);
            end
            st_q.pop_valid <= 1'b0;
            st_q.pop_data  <= '0;
            st_q.pop_addr  <= '0;
            st_q.push_drop <= 1'b0;
            st_q.pop_err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_valid     = st_q.pop_valid;
    assign pop_data      = st_q.pop_data;
    assign pop_addr      = st_q.pop_addr;
    assign push_drop     = st_q.push_drop;
    assign pop_err       = st_q.pop_err;
    assign out_of_blocks = fl_empty;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_status
        assign q_empty[g] = (st_q.rd_pos[g] == st_q.wr_pos[g]);
        assign q_full[g]  = (&st_q.wr_pos[g][CH_LOG2-1:0]) && fl_empty;
        assign q_chunks[g*CNT_W +: CNT_W]   = st_q.chunks[g];
        assign q_blocks[g*BCNT_W +: BCNT_W] = st_q.blocks[g];

        // R3: position-based emptiness agrees with the chunk counter
        a_r3_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
            q_empty[g] == (st_q.chunks[g] == '0));
    end

    // R6: every block is owned by exactly one queue or sits on the free list
    int owned_sum;
    always_comb begin
        owned_sum = int'(fl_count_raw);
        for (int q = 0; q < NUM_Q; q++) owned_sum += int'(st_q.blocks[q]);
    end

    a_r6_blocks_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        owned_sum == NUM_BLK);

    a_r7_full_push_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_in_rng && q_full[push_idx]) |=> push_drop);

    a_r8_empty_pop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && pop_in_rng && q_empty[pop_idx]) |=> (pop_err && !pop_valid));

    a_r9_bad_push_index: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !push_in_rng) |=> push_drop);

endmodule

// File: tb/sqp_pool_top_tb_top.sv
`timescale 1ns/1ps
module sqp_pool_top_tb_top;

    localparam int NQ  = 6;
    localparam int NB  = 64;
    localparam int BS  = 4;
    localparam int CW  = 9;
    localparam int BW  = 7;
    localparam int NV  = 21;

    // {push_en, push_q, pop_en, pop_q, exp push_drop, exp pop_err, exp pop_valid}
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 3'd0, 1'b0, 3'd0, 3'b000},
        {1'b1, 3'd0, 1'b1, 3'd0, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd1, 3'b010},
        {1'b1, 3'd1, 1'b1, 3'd0, 3'b001},
        {1'b1, 3'd7, 1'b0, 3'd0, 3'b100},
        {1'b0, 3'd0, 1'b1, 3'd6, 3'b010},
        {1'b1, 3'd2, 1'b0, 3'd0, 3'b000},
        {1'b1, 3'd2, 1'b0, 3'd0, 3'b000},
        {1'b1, 3'd2, 1'b0, 3'd0, 3'b000},
        {1'b1, 3'd2, 1'b0, 3'd0, 3'b000},
        {1'b1, 3'd2, 1'b0, 3'd0, 3'b000},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'b010},
        {1'b1, 3'd5, 1'b1, 3'd1, 3'b001},
        {1'b0, 3'd0, 1'b1, 3'd5, 3'b001},
        {1'b1, 3'd3, 1'b1, 3'd3, 3'b010},
        {1'b0, 3'd0, 1'b1, 3'd3, 3'b001}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               push_en, pop_en;
    logic [2:0]         push_q, pop_q;
    logic [127:0]       push_data;
    logic               pop_valid, push_drop, pop_err, out_of_blocks;
    logic [127:0]       pop_data;
    logic [11:0]        pop_addr;
    logic [NQ-1:0]      q_empty, q_full;
    logic [NQ*CW-1:0]   q_chunks;
    logic [NQ*BW-1:0]   q_blocks;

    int checks = 0;
    int errors = 0;
    int seq    = 0;
    bit done   = 1'b0;

    // reference model
    int           mw [NQ];
    int           mr [NQ];
    logic [127:0] mdata [NQ][$];
    int           mblk [NQ][$];
    int           mfree [$];

    always #2 clk = ~clk;

    sqp_pool_top #(
        .GEOM   (sqp_pkg::GEOM_QUARTER),
        .NUM_Q  (NQ),
        .DATA_W (128)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_en       (push_en),
        .push_q        (push_q),
        .push_data     (push_data),
        .pop_en        (pop_en),
        .pop_q         (pop_q),
        .pop_valid     (pop_valid),
        .pop_data      (pop_data),
        .pop_addr      (pop_addr),
        .push_drop     (push_drop),
        .pop_err       (pop_err),
        .q_empty       (q_empty),
        .q_full        (q_full),
        .q_chunks      (q_chunks),
        .q_blocks      (q_blocks),
        .out_of_blocks (out_of_blocks)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mfree.delete();
        for (int b = NQ; b < NB; b++) mfree.push_back(b);
        for (int q = 0; q < NQ; q++) begin
            mw[q] = 0;
            mr[q] = 0;
            mdata[q].delete();
            mblk[q].delete();
            mblk[q].push_back(q);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push_en = 1'b0; pop_en = 1'b0; push_q = '0; pop_q = '0; push_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic check_status();
        for (int q = 0; q < NQ; q++) begin
            chk(int'(q_chunks[q*CW +: CW]) == mw[q] - mr[q], "R3 chunk count",
                128'(q_chunks[q*CW +: CW]), 128'(mw[q] - mr[q]));
            chk(q_empty[q] == (mw[q] == mr[q]), "R3 empty", 128'(q_empty[q]), 128'(mw[q] == mr[q]));
            chk(int'(q_blocks[q*BW +: BW]) == mblk[q].size(), "R6 block count",
                128'(q_blocks[q*BW +: BW]), 128'(mblk[q].size()));
            chk(q_full[q] == ((mw[q] % BS == BS - 1) && mfree.size() == 0), "R7 full flag",
                128'(q_full[q]), 128'((mw[q] % BS == BS - 1) && mfree.size() == 0));
        end
        chk(out_of_blocks == (mfree.size() == 0), "R6 out_of_blocks",
            128'(out_of_blocks), 128'(mfree.size() == 0));
    endtask

    // Called at a falling edge; drives one cycle and checks after the next rising edge.
    task automatic step(input bit pe, input int pq, input bit oe, input int oq,
                        output bit ed, output bit ee, output bit ev);
        logic [127:0] d, xd;
        int  xa;
        bit  push_ok, pop_ok, need;
        d = {32'hC0DE0000 + seq, seq * 7, ~seq, seq};
        seq++;
        xd = '0; xa = 0;
        // R10: both decisions use the state before this cycle
        pop_ok = oe && (oq < NQ) && (mw[oq] != mr[oq]);
        if (pop_ok) begin
            xd = mdata[oq][0];
            xa = (mblk[oq][0] * BS + mr[oq] % BS) * 16;
        end
        need    = (pq < NQ) && (mw[pq] % BS == BS - 1);
        push_ok = pe && (pq < NQ) && !(need && mfree.size() == 0);
        if (push_ok) begin
            mdata[pq].push_back(d);
            if (need) mblk[pq].push_back(mfree.pop_front());
            mw[pq]++;
        end
        if (pop_ok) begin
            void'(mdata[oq].pop_front());
            if (mr[oq] % BS == BS - 1) mfree.push_back(mblk[oq].pop_front());
            mr[oq]++;
        end
        ed = pe && !push_ok;
        ee = oe && !pop_ok;
        ev = pop_ok;

        push_en = pe; push_q = 3'(pq); push_data = d;
        pop_en  = oe; pop_q  = 3'(oq);
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0;

        chk(push_drop == ed, (pq >= NQ) ? "R9 push drop" : "R7 push drop", 128'(push_drop), 128'(ed));
        chk(pop_err == ee, (oq >= NQ) ? "R9 pop err" : "R8 pop err", 128'(pop_err), 128'(ee));
        chk(pop_valid == ev, "R2 pop valid", 128'(pop_valid), 128'(ev));
        if (ev) begin
            chk(pop_data == xd, "R2 pop data order", pop_data, xd);
            chk(int'(pop_addr) == xa, "R4 pop address", 128'(pop_addr), 128'(xa));
        end
        check_status();
    endtask

    initial begin
        bit ed, ee, ev;
        int cap;
        rst_n = 1'b0;
        do_reset();

        // R1: reset state
        chk(q_empty == '1, "R1 all empty", 128'(q_empty), 128'('1));
        chk(q_full == '0, "R1 none full", 128'(q_full), 128'(0));
        chk(out_of_blocks == 1'b0, "R1 free blocks present", 128'(out_of_blocks), 128'(0));
        chk(pop_valid == 1'b0 && push_drop == 1'b0 && pop_err == 1'b0, "R1 no pulses",
            128'({pop_valid, push_drop, pop_err}), 128'(0));
        check_status();

        // table walk: R2 R4 R5 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            step(v[10], int'(v[9:7]), v[6], int'(v[5:3]), ed, ee, ev);
            chk({ed, ee, ev} == v[2:0], "R10 table outcome", 128'({ed, ee, ev}), 128'(v[2:0]));
        end

        // R1: reset restores ownership of one block per queue
        do_reset();
        check_status();

        // R11 and R7: fill queue 1 until the pool is exhausted
        cap = 0;
        for (int k = 0; k < 240; k++) begin
            step(1'b1, 1, 1'b0, 0, ed, ee, ev);
            if (ed) break;
            cap++;
        end
        chk(cap == 235, "R11 quarter capacity", 128'(cap), 128'(235));
        chk(out_of_blocks == 1'b1, "R6 pool exhausted", 128'(out_of_blocks), 128'(1));
        chk(q_full[1] == 1'b1, "R7 queue 1 full", 128'(q_full[1]), 128'(1));

        // R7: queue 0 still has room inside its own block
        step(1'b1, 0, 1'b0, 0, ed, ee, ev);
        chk(ed == 1'b0, "R7 other queue accepted", 128'(ed), 128'(0));

        // pop to the last chunk of queue 1's oldest block
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b1, 1, ed, ee, ev);

        // R10: the freeing pop does not feed the same-cycle push
        step(1'b1, 1, 1'b1, 1, ed, ee, ev);
        chk(ed == 1'b1, "R10 push refused", 128'(ed), 128'(1));
        chk(ev == 1'b1, "R10 pop serviced", 128'(ev), 128'(1));
        chk(out_of_blocks == 1'b0, "R6 block returned", 128'(out_of_blocks), 128'(0));

        // R5: the returned block is reused by the next push
        step(1'b1, 1, 1'b0, 0, ed, ee, ev);
        chk(ed == 1'b0, "R5 recycled block taken", 128'(ed), 128'(0));
        chk(mblk[1][mblk[1].size()-1] == 1, "R5 reuse order", 128'(mblk[1][mblk[1].size()-1]), 128'(1));

        // drain both queues through the linked chain, addresses checked per pop
        while (mw[1] != mr[1]) step(1'b0, 0, 1'b1, 1, ed, ee, ev);
        while (mw[0] != mr[0]) step(1'b0, 0, 1'b1, 0, ed, ee, ev);
        step(1'b0, 0, 1'b1, 1, ed, ee, ev);
        chk(ee == 1'b1, "R8 drained queue empty", 128'(ee), 128'(1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule